// File: doc/BRIEF.md
# USB Endpoint Status and Interrupt Unit

This unit keeps the status of one endpoint of a USB device controller and raises that endpoint's interrupt. The packet engine sends it single-cycle event pulses: a stall handshake went out, an isochronous OUT packet had a CRC error, a packet was received or acknowledged, a short packet went out at the end of a DMA transfer, a SETUP arrived, and a bank was filled or released. The unit keeps three sticky flags, a two-bit data toggle field and a busy-bank counter.

Software raises and drops a stall request through separate set and clear strobes. It writes a four-bit enable mask and acknowledges flags by writing ones to a clear vector. The single interrupt output is the registered OR of every enabled flag and of the "all banks free" condition.

Top module: `ep_stat_irq`

## Requirements
- R1: After reset the flags, the enable mask and the stall request are 0. The toggle field is 01, the busy count is 0 and irq_o is 0.
- R2: stall_set_i sets stall_req_o and stall_clr_i clears it. flags_o[0] (stall) is set by ev_stall_sent_i only while stall_req_o is 1.
- R3: flags_o[1] (CRC error) is set by ev_crc_err_i only when the endpoint is isochronous (cfg_iso_i=1) and OUT (cfg_in_i=0).
- R4: On a non-control OUT endpoint, ev_pkt_rx_i with rx_short_i=1 sets flags_o[2] (short packet).
- R5: On a non-control IN endpoint, ev_tx_short_i sets flags_o[2] only when cfg_dma_end_i and cfg_auto_sw_i are both 1. A control endpoint never sets the short flag.
- R6: A 1 on bit k of clr_i clears flags_o[k]. If a set event hits the same flag in the same cycle, the set wins.
- R7: irq_o is a register. In each cycle it equals the OR of (flags_o[k] AND en_o[k]) for k=0..2, together with (en_o[3] AND busy_o==0), taken from the previous cycle.
- R8: On an IN endpoint, each ev_tx_ack_i moves the toggle field between 00 (DATA0) and 01 (DATA1).
- R9: On an OUT endpoint, each ev_pkt_rx_i loads the toggle field with {0, rx_pid_i}.
- R10: ev_setup_i takes priority over the other toggle events. It sets the toggle field to 01 on an IN endpoint and to 00 on an OUT endpoint, so the next data stage uses DATA1.
- R11: busy_o counts up on ev_bank_fill_i and down on ev_bank_rel_i. It saturates at NB_BANKS and at 0. When both events come in the same cycle, the count does not change.
- R12: en_wr_i loads en_o from en_wdata_i. Bits 0..2 enable the matching flag and bit 3 enables the interrupt for busy_o==0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_in_i | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_ctrl_i | input | 1 | Control endpoint |
| cfg_iso_i | input | 1 | Isochronous endpoint |
| cfg_dma_end_i | input | 1 | End-of-DMA-buffer short packet enable |
| cfg_auto_sw_i | input | 1 | Automatic bank switch enable |
| ev_stall_sent_i | input | 1 | STALL handshake sent |
| ev_crc_err_i | input | 1 | CRC error on a received packet |
| ev_pkt_rx_i | input | 1 | OUT packet accepted into a bank |
| rx_short_i | input | 1 | The accepted packet is short |
| rx_pid_i | input | 1 | PID of the accepted packet (0 = DATA0, 1 = DATA1) |
| ev_tx_ack_i | input | 1 | IN packet acknowledged |
| ev_tx_short_i | input | 1 | Short IN packet sent at the end of a DMA transfer |
| ev_setup_i | input | 1 | SETUP packet received |
| ev_bank_fill_i | input | 1 | Bank filled |
| ev_bank_rel_i | input | 1 | Bank released |
| stall_set_i | input | 1 | Raise the stall request |
| stall_clr_i | input | 1 | Drop the stall request |
| clr_i | input | 3 | Write-one-to-clear strobe for the flags |
| en_wr_i | input | 1 | Enable mask write strobe |
| en_wdata_i | input | 4 | Enable mask write data |
| stall_req_o | output | 1 | Stall request |
| flags_o | output | 3 | Sticky flags: [0] stall, [1] CRC, [2] short |
| en_o | output | 4 | Enable mask |
| dtseq_o | output | 2 | Data toggle field |
| busy_o | output | 2 | Busy bank count |
| irq_o | output | 1 | Combined endpoint interrupt |

## Verification
Flags, the toggle field, the busy count, the enable mask and the stall request change on the first rising edge after their stimulus. irq_o follows one edge later. The bench drives its inputs and samples the outputs on falling edges. It reads state values one falling edge after the stimulus and irq_o two falling edges after it. It also checks that irq_o still holds its old value at the first of those two edges. A reference model inside the bench follows the toggle field and the busy count at every step of the sweeps.

// File: rtl/ep_stat_pkg.sv
package ep_stat_pkg;
  localparam int unsigned N_FLAG = 3;
  localparam int unsigned N_EN   = N_FLAG + 1;
  localparam int unsigned CNT_W  = 2;
  localparam int unsigned FL_STALL = 0;
  localparam int unsigned FL_CRC   = 1;
  localparam int unsigned FL_SHORT = 2;
  localparam int unsigned EN_EMPTY = N_FLAG;
  localparam logic [1:0] TOG_D0 = 2'b00;
  localparam logic [1:0] TOG_D1 = 2'b01;
endpackage

// File: rtl/ep_flag_bank.sv
module ep_flag_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= set_i[k] | (q & ~clr_i[k]);  // set wins
    end
    assign flag_o[k] = q;
  end
endmodule

// File: rtl/ep_toggle.sv
module ep_toggle
  import ep_stat_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dir_in_i,
  input  logic       setup_i,
  input  logic       tx_ack_i,
  input  logic       rx_pkt_i,
  input  logic       rx_pid_i,
  output logic [1:0] dtseq_o
);
  logic [1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  q <= TOG_D1;
    else if (setup_i)             q <= dir_in_i ? TOG_D1 : TOG_D0;
    else if (dir_in_i && tx_ack_i) q <= {1'b0, ~q[0]};
    else if (!dir_in_i && rx_pkt_i) q <= {1'b0, rx_pid_i};
  end
  assign dtseq_o = q;
endmodule

// File: rtl/ep_bank_cnt.sv
module ep_bank_cnt #(
  parameter int unsigned NB = 2,
  parameter int unsigned W  = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fill_i,
  input  logic         rel_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = W'(NB);
  logic [W-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else if (fill_i && !rel_i && q != MAX) q <= q + 1'b1;
    else if (rel_i && !fill_i && q != '0)  q <= q - 1'b1;
  end
  assign cnt_o = q;
endmodule

// File: rtl/ep_stat_irq.sv
module ep_stat_irq
  import ep_stat_pkg::*;
#(
  parameter int unsigned NB_BANKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_in_i,
  input  logic              cfg_ctrl_i,
  input  logic              cfg_iso_i,
  input  logic              cfg_dma_end_i,
  input  logic              cfg_auto_sw_i,
  input  logic              ev_stall_sent_i,
  input  logic              ev_crc_err_i,
  input  logic              ev_pkt_rx_i,
  input  logic              rx_short_i,
  input  logic              rx_pid_i,
  input  logic              ev_tx_ack_i,
  input  logic              ev_tx_short_i,
  input  logic              ev_setup_i,
  input  logic              ev_bank_fill_i,
  input  logic              ev_bank_rel_i,
  input  logic              stall_set_i,
  input  logic              stall_clr_i,
  input  logic [N_FLAG-1:0] clr_i,
  input  logic              en_wr_i,
  input  logic [N_EN-1:0]   en_wdata_i,
  output logic              stall_req_o,
  output logic [N_FLAG-1:0] flags_o,
  output logic [N_EN-1:0]   en_o,
  output logic [1:0]        dtseq_o,
  output logic [CNT_W-1:0]  busy_o,
  output logic              irq_o
);
  logic              stall_req_q;
  logic [N_EN-1:0]   en_q;
  logic              irq_q;
  logic [N_FLAG-1:0] set_vec;
  logic              short_out, short_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          stall_req_q <= 1'b0;
    else if (stall_set_i) stall_req_q <= 1'b1;
    else if (stall_clr_i) stall_req_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_wr_i) en_q <= en_wdata_i;
  end

  assign short_out = !cfg_ctrl_i && !cfg_in_i && ev_pkt_rx_i && rx_short_i;
  assign short_in  = !cfg_ctrl_i && cfg_in_i && ev_tx_short_i
                     && cfg_dma_end_i && cfg_auto_sw_i;

  always_comb begin
    set_vec           = '0;
    set_vec[FL_STALL] = ev_stall_sent_i && stall_req_q;
    set_vec[FL_CRC]   = ev_crc_err_i && cfg_iso_i && !cfg_in_i;
    set_vec[FL_SHORT] = short_out || short_in;
  end

  ep_flag_bank #(.N(N_FLAG)) u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_vec),
    .clr_i (clr_i),
    .flag_o(flags_o)
  );

  ep_toggle u_tog (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dir_in_i(cfg_in_i),
    .setup_i (ev_setup_i),
    .tx_ack_i(ev_tx_ack_i),
    .rx_pkt_i(ev_pkt_rx_i),
    .rx_pid_i(rx_pid_i),
    .dtseq_o (dtseq_o)
  );

  ep_bank_cnt #(.NB(NB_BANKS), .W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fill_i(ev_bank_fill_i),
    .rel_i (ev_bank_rel_i),
    .cnt_o (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else irq_q <= |(flags_o & en_q[N_FLAG-1:0])
                  || (en_q[EN_EMPTY] && busy_o == '0);
  end

  assign stall_req_o = stall_req_q;
  assign en_o        = en_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/ep_stat_irq_chk.sv
module ep_stat_irq_chk
  import ep_stat_pkg::*;
#(
  parameter int unsigned NB_BANKS = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_in_i,
  input logic              cfg_iso_i,
  input logic              ev_stall_sent_i,
  input logic              ev_crc_err_i,
  input logic              ev_bank_fill_i,
  input logic              ev_bank_rel_i,
  input logic [N_FLAG-1:0] clr_i,
  input logic              stall_req_o,
  input logic [N_FLAG-1:0] flags_o,
  input logic [N_EN-1:0]   en_o,
  input logic [1:0]        dtseq_o,
  input logic [CNT_W-1:0]  busy_o,
  input logic              irq_o
);
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_stall_sent_i && stall_req_o && clr_i[0]) |=> flags_o[0]); // R6
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[1] && !ev_crc_err_i) |=> !flags_o[1]); // R6
  AST_CRC_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flags_o[1] && (cfg_in_i || !cfg_iso_i)) |=> !flags_o[1]); // R3
  AST_STALL_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flags_o[0] && !stall_req_o) |=> !flags_o[0]); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o <= CNT_W'(NB_BANKS)); // R11
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_bank_fill_i && ev_bank_rel_i) |=> $stable(busy_o)); // R11
  AST_TOG_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dtseq_o[1] == 1'b0); // R8
  AST_IRQ_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flags_o & en_o[N_FLAG-1:0]) || (en_o[N_FLAG] && busy_o == '0)) |=> irq_o); // R7
endmodule

bind ep_stat_irq ep_stat_irq_chk #(.NB_BANKS(NB_BANKS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_in_i       (cfg_in_i),
  .cfg_iso_i      (cfg_iso_i),
  .ev_stall_sent_i(ev_stall_sent_i),
  .ev_crc_err_i   (ev_crc_err_i),
  .ev_bank_fill_i (ev_bank_fill_i),
  .ev_bank_rel_i  (ev_bank_rel_i),
  .clr_i          (clr_i),
  .stall_req_o    (stall_req_o),
  .flags_o        (flags_o),
  .en_o           (en_o),
  .dtseq_o        (dtseq_o),
  .busy_o         (busy_o),
  .irq_o          (irq_o)
);

// File: tb/ep_stat_irq_tb.sv
module ep_stat_irq_tb;
  localparam int NB = 2;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_in_i, cfg_ctrl_i, cfg_iso_i, cfg_dma_end_i, cfg_auto_sw_i;
  logic ev_stall_sent_i, ev_crc_err_i, ev_pkt_rx_i, rx_short_i, rx_pid_i;
  logic ev_tx_ack_i, ev_tx_short_i, ev_setup_i, ev_bank_fill_i, ev_bank_rel_i;
  logic stall_set_i, stall_clr_i, en_wr_i;
  logic [2:0] clr_i;
  logic [3:0] en_wdata_i;
  logic stall_req_o, irq_o;
  logic [2:0] flags_o;
  logic [3:0] en_o;
  logic [1:0] dtseq_o, busy_o;

  int total = 0, bad = 0;
  logic [1:0] m_tog = 2'b01;
  int m_cnt = 0;

  always #2 clk_i = ~clk_i;

  ep_stat_irq #(.NB_BANKS(NB)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    {ev_stall_sent_i, ev_crc_err_i, ev_pkt_rx_i, rx_short_i, rx_pid_i} = '0;
    {ev_tx_ack_i, ev_tx_short_i, ev_setup_i, ev_bank_fill_i, ev_bank_rel_i} = '0;
    {stall_set_i, stall_clr_i, en_wr_i} = '0;
    clr_i = '0;
    en_wdata_i = '0;
  endtask

  // one edge with the currently driven inputs; update models; release pulses
  task automatic tick();
    if (ev_setup_i) m_tog = cfg_in_i ? 2'b01 : 2'b00;
    else if (cfg_in_i && ev_tx_ack_i) m_tog = {1'b0, ~m_tog[0]};
    else if (!cfg_in_i && ev_pkt_rx_i) m_tog = {1'b0, rx_pid_i};
    if (ev_bank_fill_i && !ev_bank_rel_i && m_cnt < NB) m_cnt++;
    else if (ev_bank_rel_i && !ev_bank_fill_i && m_cnt > 0) m_cnt--;
    @(negedge clk_i);
    idle();
  endtask

  task automatic clear_all();
    clr_i = 3'b111;
    tick();
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    {cfg_in_i, cfg_ctrl_i, cfg_iso_i, cfg_dma_end_i, cfg_auto_sw_i} = '0;
    repeat (2) @(negedge clk_i);
    // R1
    chk(flags_o == 0 && en_o == 0 && stall_req_o == 0, "R1 flags/en/req", {flags_o, en_o}, 0);
    chk(dtseq_o == 2'b01 && busy_o == 0 && irq_o == 0, "R1 tog/cnt/irq", {dtseq_o, busy_o}, 4);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2
    ev_stall_sent_i = 1; tick();
    chk(flags_o[0] == 0, "R2 stall without req", flags_o[0], 0);
    stall_set_i = 1; tick();
    chk(stall_req_o == 1, "R2 req set", stall_req_o, 1);
    ev_stall_sent_i = 1; tick();
    chk(flags_o[0] == 1, "R2 stall flag", flags_o[0], 1);
    // R6
    clr_i = 3'b001; tick();
    chk(flags_o[0] == 0, "R6 w1c", flags_o[0], 0);
    ev_stall_sent_i = 1; tick();
    ev_stall_sent_i = 1; clr_i = 3'b001; tick();
    chk(flags_o[0] == 1, "R6 set wins", flags_o[0], 1);
    clr_i = 3'b110; tick();
    chk(flags_o[0] == 1, "R6 other clr bits", flags_o[0], 1);
    stall_clr_i = 1; tick();
    chk(stall_req_o == 0, "R2 req clr", stall_req_o, 0);
    clear_all();

    // R3 sweep
    for (int c = 0; c < 4; c++) begin
      cfg_in_i = c[0]; cfg_iso_i = c[1];
      ev_crc_err_i = 1; tick();
      chk(flags_o[1] == (c[1] & ~c[0]), "R3 crc gating", flags_o[1], c[1] & ~c[0]);
      clear_all();
    end
    cfg_iso_i = 0;

    // R4 R5 sweep over in, ctrl, dma_end, auto_sw, short
    for (int c = 0; c < 32; c++) begin
      bit exp;
      {cfg_in_i, cfg_ctrl_i, cfg_dma_end_i, cfg_auto_sw_i} = c[3:0];
      rx_short_i = c[4];
      ev_pkt_rx_i = ~c[3];
      ev_tx_short_i = c[3];
      exp = !c[2] && (c[3] ? (c[1] && c[0]) : c[4]);
      tick();
      chk(flags_o[2] == exp, c[3] ? "R5 short in" : "R4 short out", flags_o[2], exp);
      chk(dtseq_o == m_tog, "R9 tog during sweep", dtseq_o, m_tog);
      clear_all();
    end
    {cfg_in_i, cfg_ctrl_i, cfg_dma_end_i, cfg_auto_sw_i} = '0;

    // R12 R7: empty interrupt, latency
    en_wr_i = 1; en_wdata_i = 4'b1000; tick();
    chk(en_o == 4'b1000, "R12 en write", en_o, 8);
    chk(irq_o == 0, "R7 latency", irq_o, 0);
    @(negedge clk_i);
    chk(irq_o == 1, "R12 empty irq", irq_o, 1);
    ev_bank_fill_i = 1; tick();
    chk(busy_o == 1, "R11 fill", busy_o, 1);
    @(negedge clk_i);
    chk(irq_o == 0, "R12 irq drops", irq_o, 0);
    // R7: flag vs mask
    en_wr_i = 1; en_wdata_i = 4'b0100; tick();
    cfg_in_i = 0; ev_pkt_rx_i = 1; rx_short_i = 1; tick();
    chk(irq_o == 0, "R7 one cycle after flag", irq_o, 0);
    @(negedge clk_i);
    chk(irq_o == 1, "R7 enabled flag", irq_o, 1);
    en_wr_i = 1; en_wdata_i = 4'b0011; tick(); @(negedge clk_i);
    chk(irq_o == 0, "R7 masked flag", irq_o, 0);
    clear_all();
    ev_bank_rel_i = 1; tick();

    // R11 sweep
    for (int i = 0; i < 60; i++) begin
      ev_bank_fill_i = (i % 3) != 2;
      ev_bank_rel_i  = (i % 5) >= 2 || (i > 40 && (i % 2) == 0);
      tick();
      chk(busy_o == m_cnt, "R11 count", busy_o, m_cnt);
    end

    // R8 R9 R10
    cfg_in_i = 1;
    for (int i = 0; i < 5; i++) begin
      ev_tx_ack_i = 1; ev_pkt_rx_i = 1; rx_pid_i = 1; tick();
      chk(dtseq_o == m_tog, "R8 in flip", dtseq_o, m_tog);
    end
    ev_setup_i = 1; ev_tx_ack_i = 1; tick();
    chk(dtseq_o == 2'b01, "R10 setup in", dtseq_o, 1);
    cfg_in_i = 0;
    for (int i = 0; i < 6; i++) begin
      ev_pkt_rx_i = 1; rx_pid_i = i[1]; ev_tx_ack_i = 1; tick();
      chk(dtseq_o == m_tog, "R9 out capture", dtseq_o, m_tog);
    end
    ev_setup_i = 1; ev_pkt_rx_i = 1; rx_pid_i = 1; tick();
    chk(dtseq_o == 2'b00, "R10 setup out", dtseq_o, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule